// File: doc/BRIEF.md
# Two-Channel Round-Robin Stream Merger

This block merges two word streams into one output stream. Each input offers a data word, a byte-empty count and a valid flag, and receives a ready flag. The output presents the selected word, its empty count, a source tag and a valid flag, and takes a ready flag from downstream as backpressure. All handshakes have ready latency 0: a word moves in any cycle where valid and ready are both high on that link.

Arbitration is per word and alternates between the channels. When both enabled channels hold a word and downstream accepts, the accepted words come from channel 0 and channel 1 in turn. A channel with nothing to send never delays the other one. A two-bit enable mask can take either channel out of arbitration. Any rule that keeps whole packets together has to be enforced by the sources.

Top module: `rr2_stream_merge`

## Requirements
- R1: While `rst_n` is low, and in the cycle in which it is released, `m_valid`, `a0_ready` and `a1_ready` are low. The first grant after reset goes to channel 0 when both channels are valid.
- R2: A word is taken from a channel only in a cycle where that channel's valid and ready are both high. A word that is held until then arrives exactly once, and each channel's words leave in the order they entered.
- R3: While both enabled channels are valid and `m_ready` is high, consecutive accepted words alternate in source: 0, 1, 0, 1.
- R4: `en_mask[0]` gates channel 0 and `en_mask[1]` gates channel 1. A channel whose bit is 0 is never granted, and its ready stays low.
- R5: While `m_ready` is low, both input readies are low and the turn pointer holds. The channel that was due before the stall is granted first after it.
- R6: When only one enabled channel is valid, that channel is granted in every cycle in which `m_ready` is high.
- R7: `m_data` and `m_empty` carry the granted channel's word and empty count. `m_src` is 0 for channel 0 and 1 for channel 1. `m_valid` is high when any enabled channel is valid.
- R8: Ready latency is 0. `m_valid` and the input ready respond combinationally in the same cycle as the input valid and `m_ready`, with no added register stage.
- R9: `DATA_W` may be 128, 256 or 512. The empty field is `$clog2(DATA_W/8)` bits wide and passes any value, including all-ones, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_mask | input | 2 | Per-channel enable; bit 0 = channel 0, bit 1 = channel 1 |
| a0_data | input | DATA_W | Channel 0 word |
| a0_empty | input | EMPTY_W | Channel 0 unused byte count |
| a0_valid | input | 1 | Channel 0 has a word |
| a0_ready | output | 1 | Channel 0 word taken this cycle if valid |
| a1_data | input | DATA_W | Channel 1 word |
| a1_empty | input | EMPTY_W | Channel 1 unused byte count |
| a1_valid | input | 1 | Channel 1 has a word |
| a1_ready | output | 1 | Channel 1 word taken this cycle if valid |
| m_data | output | DATA_W | Merged word |
| m_empty | output | EMPTY_W | Merged unused byte count |
| m_src | output | 1 | Source channel of the merged word |
| m_valid | output | 1 | Merged word present |
| m_ready | input | 1 | Downstream accepts the merged word |

## Verification
In every cycle the assertions check the following: at most one input is ready; readies follow the enable mask and downstream stalls; a ready channel's word, empty count and tag appear on the output; the source alternates across back-to-back dual-valid accepts; and the turn is kept through a stall. The properties that span many cycles are left to the bench scenarios. Only those scenarios can show that no word is lost or duplicated and that the order within each channel is kept. The same holds for the reset behaviour and the first grant after reset.

// File: rtl/rr2_stream_merge.sv
module rr2_stream_merge #(
  parameter int DATA_W = 128,
  localparam int EMPTY_W = $clog2(DATA_W/8)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         en_mask,
  input  logic [DATA_W-1:0]  a0_data,
  input  logic [EMPTY_W-1:0] a0_empty,
  input  logic               a0_valid,
  output logic               a0_ready,
  input  logic [DATA_W-1:0]  a1_data,
  input  logic [EMPTY_W-1:0] a1_empty,
  input  logic               a1_valid,
  output logic               a1_ready,
  output logic [DATA_W-1:0]  m_data,
  output logic [EMPTY_W-1:0] m_empty,
  output logic               m_src,
  output logic               m_valid,
  input  logic               m_ready
);

  logic live, turn1;
  logic req0, req1, gnt0, gnt1, fire;

  assign req0 = a0_valid & en_mask[0];
  assign req1 = a1_valid & en_mask[1];
  assign gnt1 = req1 & (~req0 | turn1);
  assign gnt0 = req0 & ~gnt1;

  assign m_valid  = live & (req0 | req1);
  assign fire     = m_valid & m_ready;
  assign a0_ready = live & m_ready & gnt0;
  assign a1_ready = live & m_ready & gnt1;

  assign m_src   = gnt1;
  assign m_data  = gnt1 ? a1_data  : a0_data;
  assign m_empty = gnt1 ? a1_empty : a0_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live  <= 1'b0;
      turn1 <= 1'b0;
    end else begin
      live <= 1'b1;
      if (fire) turn1 <= gnt0;
    end
  end

endmodule

// File: rtl/rr2_stream_merge_chk.sv
module rr2_stream_merge_chk #(
  parameter int DATA_W = 128,
  localparam int EMPTY_W = $clog2(DATA_W/8)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         en_mask,
  input logic [DATA_W-1:0]  a0_data,
  input logic [EMPTY_W-1:0] a0_empty,
  input logic               a0_valid,
  input logic               a0_ready,
  input logic [DATA_W-1:0]  a1_data,
  input logic [EMPTY_W-1:0] a1_empty,
  input logic               a1_valid,
  input logic               a1_ready,
  input logic [DATA_W-1:0]  m_data,
  input logic [EMPTY_W-1:0] m_empty,
  input logic               m_src,
  input logic               m_valid,
  input logic               m_ready
);

  logic both, both_fire, both_stall;
  logic prev_both_fire, prev_both_stall, prev_src;

  assign both       = a0_valid & en_mask[0] & a1_valid & en_mask[1];
  assign both_fire  = both & m_valid & m_ready;
  assign both_stall = both & ~m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_both_fire  <= 1'b0;
      prev_both_stall <= 1'b0;
      prev_src        <= 1'b0;
    end else begin
      prev_both_fire  <= both_fire;
      prev_both_stall <= both_stall;
      prev_src        <= m_src;
    end
  end

  // R2
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a0_ready |-> a0_valid) and (a1_ready |-> a1_valid));

  // R4
  mask_gates_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_mask[0] |-> !a0_ready) and (!en_mask[1] |-> !a1_ready));

  // R5
  stall_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !m_ready |-> (!a0_ready && !a1_ready));

  // R5
  stall_keeps_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_both_stall && both) |-> (m_src == prev_src));

  // R3
  strict_alternation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_both_fire && both_fire) |-> (m_src != prev_src));

  // R7
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a0_ready && a1_ready));

  // R7
  path0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a0_ready |-> (m_data == a0_data && m_empty == a0_empty && !m_src && m_valid));

  // R7
  path1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a1_ready |-> (m_data == a1_data && m_empty == a1_empty && m_src && m_valid));

  // R6
  work_conserving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready) |-> (a0_ready || a1_ready));

endmodule

bind rr2_stream_merge rr2_stream_merge_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_rr2_stream_merge.sv
`timescale 1ns/1ps
module sim_rr2_stream_merge;
  localparam int DATA_W  = 128;
  localparam int EMPTY_W = $clog2(DATA_W/8);
  localparam int NVEC    = 14;
  // {en[1:0], v0, v1, m_ready, exp_r0, exp_r1, exp_mv, exp_src}
  localparam logic [8:0] VEC [NVEC] = '{
    9'b11_111_1010, 9'b11_111_0111, 9'b11_111_1010, 9'b11_110_0011,
    9'b11_111_0111, 9'b11_101_1010, 9'b11_101_1010, 9'b10_111_0111,
    9'b10_101_0000, 9'b01_011_0000, 9'b00_111_0000, 9'b01_111_1010,
    9'b11_001_0000, 9'b11_111_0111
  };

  logic clk = 0, rst_n = 0;
  logic [1:0] en_mask = 2'b11;
  logic [DATA_W-1:0] a0_data = '0, a1_data = '0;
  logic [EMPTY_W-1:0] a0_empty = '0, a1_empty = '0;
  logic a0_valid = 0, a1_valid = 0, m_ready = 0;
  logic a0_ready, a1_ready, m_src, m_valid;
  logic [DATA_W-1:0] m_data;
  logic [EMPTY_W-1:0] m_empty;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rr2_stream_merge #(.DATA_W(DATA_W)) u0 (.*);

  function automatic logic [DATA_W-1:0] word(input int ch, input int seq);
    logic [31:0] w;
    w = {ch[0], seq[30:0]};
    return {(DATA_W/32){w}};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  int seq0, seq1, got0, got1;
  bit prev_bf, prev_s, acc0, acc1;

  initial begin
    // R1: outputs quiet in reset even with traffic offered
    a0_valid = 1; a1_valid = 1; m_ready = 1;
    repeat (3) @(negedge clk);
    chk(!m_valid && !a0_ready && !a1_ready, "R1 in reset", {m_valid, a0_ready, a1_ready}, 0);
    rst_n = 1; #1;
    chk(!m_valid && !a0_ready && !a1_ready, "R1 release cycle", {m_valid, a0_ready, a1_ready}, 0);
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [8:0] v;
      v = VEC[i];
      en_mask = v[8:7]; a0_valid = v[6]; a1_valid = v[5]; m_ready = v[4];
      a0_data = word(0, 100 + i); a1_data = word(1, 200 + i);
      a0_empty = EMPTY_W'(i); a1_empty = EMPTY_W'(15 - i);
      #2;
      chk({a0_ready, a1_ready} == v[3:2], $sformatf("R3 R4 R5 R6 vec%0d readies", i), {a0_ready, a1_ready}, v[3:2]);
      chk(m_valid == v[1], $sformatf("R7 R8 vec%0d m_valid", i), m_valid, v[1]);
      if (v[1]) begin
        chk(m_src == v[0], $sformatf("R1 R3 vec%0d m_src", i), m_src, v[0]);
        chk(m_data == (v[0] ? a1_data : a0_data), $sformatf("R7 vec%0d data", i), m_data[63:0], (v[0] ? a1_data[63:0] : a0_data[63:0]));
        chk(m_empty == (v[0] ? a1_empty : a0_empty), $sformatf("R9 vec%0d empty", i), m_empty, (v[0] ? a1_empty : a0_empty));
      end
      @(negedge clk);
    end

    // R1: first grant after a fresh reset goes to channel 0
    rst_n = 0; en_mask = 2'b11; a0_valid = 1; a1_valid = 1; m_ready = 1;
    @(negedge clk); rst_n = 1; @(negedge clk); #2;
    chk(a0_ready && !a1_ready && !m_src, "R1 first grant", {a0_ready, a1_ready, m_src}, 3'b100);

    // R2 R3 R6: random valid and backpressure, scoreboard per channel
    @(negedge clk);
    seq0 = 0; seq1 = 0; got0 = 0; got1 = 0; prev_bf = 0; prev_s = 0;
    a0_valid = 0; a1_valid = 0; acc0 = 0; acc1 = 0;
    for (int c = 0; c < 3000; c++) begin
      if (acc0) begin seq0++; a0_valid = 0; end
      if (acc1) begin seq1++; a1_valid = 0; end
      if (!a0_valid) a0_valid = (c < 1500) ? ($urandom % 4 != 0) : 1'b1;
      if (!a1_valid) a1_valid = (c < 1500) ? ($urandom % 4 != 0) : 1'b1;
      a0_data = word(0, seq0); a1_data = word(1, seq1);
      m_ready = ($urandom % 4 != 0);
      #2;
      acc0 = a0_valid && a0_ready;
      acc1 = a1_valid && a1_ready;
      if (m_valid && m_ready) begin
        chk(acc0 || acc1, "R6 accept on fire", {acc0, acc1}, 1);
        if (m_src) begin
          chk(m_data == word(1, got1), "R2 ch1 order", m_data[63:0], word(1, got1));
          got1++;
        end else begin
          chk(m_data == word(0, got0), "R2 ch0 order", m_data[63:0], word(0, got0));
          got0++;
        end
        if (prev_bf && a0_valid && a1_valid)
          chk(m_src != prev_s, "R3 alternate", m_src, !prev_s);
      end
      prev_bf = a0_valid && a1_valid && m_ready;
      prev_s = m_src;
      @(negedge clk);
    end
    chk(got0 > 500 && got1 > 500, "R2 both channels served", {got0[31:0], got1[31:0]}, 64'd500);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule